// File: doc/BRIEF.md
# Nested Page Table Walker

This block translates a guest-physical address into a host-physical address by walking a four-level second-stage translation table in memory. A request carries the guest address, a root pointer and the kind of access wanted (read, write, execute). The walker reads one 64-bit entry per level through a single-outstanding memory port. It checks each entry as it arrives and then either descends to the next table or stops with a fault. When the walk succeeds it reports the host-physical address.

Each entry address is the 4 KB-aligned table base with a 9-bit slice of the guest address spliced in as the entry index. The walker can keep accessed flags: when the root pointer enables this, every entry that passes its checks with the flag clear is written back with the flag set, before the walker moves on. A walk ends with a one-cycle completion pulse and a 2-bit status.

Top module: `npt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. No memory request is issued while `req_ready` is high.
- R2: The first read address is made of bits 63:52 zero, then root bits 51:12, then guest bits 47:39, then bits 2:0 zero.
- R3: Each later read uses the previous entry's bits 51:12 as its base. The index slices for levels 0 to 3 are guest bits 47:39, 38:30, 29:21 and 20:12, in that order. A walk makes at most four reads.
- R4: An entry whose bits 2:0 are all zero ends the walk with status 1 (not present) and no further memory access.
- R5: `req_acc` bit 0 requests read, bit 1 write and bit 2 execute. If a requested bit is clear in bits 2:0 of a present entry, the walk ends with status 2 (permission fault).
- R6: A present entry with any of bits 7:3 set, or any bit from PA_W up to 51 set, ends the walk with status 3 (misconfiguration). Not-present takes priority over misconfiguration, and misconfiguration takes priority over a permission fault.
- R7: Entry bits 11:9 and 63:52 have no effect on the outcome. Neither has bit 8 when tracking is off.
- R8: When root bit 6 is 1 and an entry that passes its checks has bit 8 clear, one write of that entry with bit 8 set goes to the same address, before the next read or the completion. No write happens when bit 8 is already set, when root bit 6 is 0, or for a faulting entry.
- R9: A walk that passes all four levels gives status 0, with `hpa` equal to the last entry's bits 51:12 followed by guest bits 11:0.
- R10: `done` is high for exactly one cycle per walk. The walker is ready again in the following cycle.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the address, the write flag and the write data stay unchanged.
- R12: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_gpa | input | 48 | Guest-physical address |
| req_root | input | 64 | Root pointer: bits 51:12 top table base, bit 6 accessed-flag enable |
| req_acc | input | 3 | Requested access: bit 0 read, bit 1 write, bit 2 execute |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 for the accessed-flag write, 0 for an entry read |
| mem_req_addr | output | 64 | Entry byte address |
| mem_req_wdata | output | 64 | Write data (entry with bit 8 set) |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| done | output | 1 | One-cycle walk completion pulse |
| status | output | 2 | 0 ok, 1 not present, 2 permission, 3 misconfiguration |
| hpa | output | 52 | Host-physical address, valid with status 0 |

## Verification
Two checks meet in the same check cycle: the reserved-bit test and the permission test both look at one entry, and the walker must pick one outcome. The bench builds entries that fail both tests at once, and entries that also have bits 2:0 zero. It judges that the status follows the stated priority and that the walk stops at that level. A second overlap is the accessed-flag write-back on the final level, where the write must appear before the completion pulse. The bench compares the full logged sequence of reads and writes against the sequence it derives itself.

// File: rtl/npt_pkg.sv
package npt_pkg;
    localparam int GPA_W  = 48;
    localparam int LEVELS = 4;
    localparam int IDX_W  = 9;
    localparam int PG_SH  = 12;
    localparam int ENT_W  = 64;
    localparam int BASE_W = 52 - PG_SH;
    localparam int VPN_W  = GPA_W - PG_SH;
    localparam int LVL_W  = $clog2(LEVELS);

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_CHECK, ST_WB, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        WS_OK, WS_NOT_PRESENT, WS_PERM, WS_MISCFG
    } walk_status_e;

    typedef struct packed {
        walk_state_e         state;
        logic [LVL_W-1:0]    level;
        logic                issued;
        logic [GPA_W-1:0]    gpa;
        logic [BASE_W-1:0]   base;
        logic [2:0]          acc;
        logic                ad_en;
        logic [ENT_W-1:0]    entry;
        walk_status_e        status;
        logic [51:0]         hpa;
    } walk_q_t;
endpackage

// File: rtl/npt_addr_gen.sv
module npt_addr_gen
    import npt_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [LVL_W-1:0]  level,
    output logic [ENT_W-1:0]  addr
);
    logic [IDX_W-1:0] slice [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[VPN_W-1-IDX_W*g -: IDX_W];
    end

    assign addr = {{(ENT_W-BASE_W-PG_SH){1'b0}}, base, slice[level], 3'b000};
endmodule

// File: rtl/npt_entry_chk.sv
module npt_entry_chk
    import npt_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [2:0]       acc,
    input  logic             ad_en,
    output walk_status_e     verdict,
    output logic             need_wb
);
    localparam logic [ENT_W-1:0] HI_RSV = ((64'h1 << 52) - 64'h1) & ~((64'h1 << PA_W) - 64'h1);

    logic present, rsv_bad, perm_bad;
    logic unused_fields;

    assign present  = |entry[2:0];
    assign rsv_bad  = (|entry[7:3]) || (|(entry & HI_RSV));
    assign perm_bad = |(acc & ~entry[2:0]);
    assign unused_fields = ^{entry[63:52], entry[11:9], entry[PA_W-1:12]};

    always_comb begin
        if (!present)      verdict = WS_NOT_PRESENT;
        else if (rsv_bad)  verdict = WS_MISCFG;
        else if (perm_bad) verdict = WS_PERM;
        else               verdict = WS_OK;
    end

    assign need_wb = ad_en && !entry[8];
endmodule

// File: rtl/npt_walker.sv
module npt_walker
    import npt_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [GPA_W-1:0]  req_gpa,
    input  logic [63:0]       req_root,
    input  logic [2:0]        req_acc,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ENT_W-1:0]  mem_req_addr,
    output logic [ENT_W-1:0]  mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic [1:0]        status,
    output logic [51:0]       hpa
);
    walk_q_t      q, d, adv;
    walk_status_e verdict;
    logic         need_wb;
    logic         unused_root;

    assign unused_root = ^{req_root[63:52], req_root[11:7], req_root[5:0]};

    npt_addr_gen u_addr (
        .base  (q.base),
        .vpn   (q.gpa[GPA_W-1:PG_SH]),
        .level (q.level),
        .addr  (mem_req_addr)
    );

    npt_entry_chk #(.PA_W(PA_W)) u_chk (
        .entry   (q.entry),
        .acc     (q.acc),
        .ad_en   (q.ad_en),
        .verdict (verdict),
        .need_wb (need_wb)
    );

    // State after a level has fully passed (checks and optional write-back).
    always_comb begin
        adv = q;
        if (q.level == LVL_W'(LEVELS-1)) begin
            adv.status = WS_OK;
            adv.hpa    = {q.entry[51:PG_SH], q.gpa[PG_SH-1:0]};
            adv.state  = ST_DONE;
        end else begin
            adv.level  = q.level + 1'b1;
            adv.base   = q.entry[51:PG_SH];
            adv.issued = 1'b0;
            adv.state  = ST_READ;
        end
    end

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state  = ST_READ;
                    d.level  = '0;
                    d.issued = 1'b0;
                    d.gpa    = req_gpa;
                    d.base   = req_root[51:PG_SH];
                    d.ad_en  = req_root[6];
                    d.acc    = req_acc;
                    d.status = WS_OK;
                end
            end
            ST_READ: begin
                if (!q.issued) begin
                    if (mem_req_ready) d.issued = 1'b1;
                end else if (mem_rsp_valid) begin
                    d.entry = mem_rsp_data;
                    d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (verdict != WS_OK) begin
                    d.status = verdict;
                    d.state  = ST_DONE;
                end else if (need_wb) begin
                    d.state = ST_WB;
                end else begin
                    d = adv;
                end
            end
            ST_WB: begin
                if (mem_req_ready) d = adv;
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.state == ST_IDLE);
    assign mem_req_valid = (q.state == ST_READ && !q.issued) || (q.state == ST_WB);
    assign mem_req_write = (q.state == ST_WB);
    assign mem_req_wdata = q.entry | (64'h1 << 8);
    assign done          = (q.state == ST_DONE);
    assign status        = q.status;
    assign hpa           = q.hpa;
endmodule

// File: rtl/npt_walker_chk.sv
module npt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_write,
    input logic [63:0] mem_req_addr,
    input logic [63:0] mem_req_wdata,
    input logic        mem_req_ready,
    input logic        done
);
    logic [2:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cnt <= '0;
        else if (req_valid && req_ready) rd_cnt <= '0;
        else if (mem_req_valid && !mem_req_write && mem_req_ready) rd_cnt <= rd_cnt + 1'b1;
    end

    p_idle_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    p_max_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && mem_req_ready) |-> (rd_cnt < 3'd4));

    p_wb_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[8]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
endmodule

bind npt_walker npt_walker_chk u_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_ready (mem_req_ready),
    .done          (done)
);

// File: tb/npt_walker_tb.sv
module npt_walker_tb;
    localparam int PA_W = 46;
    localparam logic [39:0] ROOT_BASE = 40'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_gpa = '0;
    logic [63:0] req_root = '0;
    logic [2:0]  req_acc = '0;
    logic        mem_req_valid, mem_req_write;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [1:0]  status;
    logic [51:0] hpa;

    int errors = 0;
    int checks = 0;
    logic stall_mode = 1'b0;

    always #5 clk = ~clk;

    npt_walker #(.PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_gpa(req_gpa), .req_root(req_root), .req_acc(req_acc),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .done(done), .status(status), .hpa(hpa)
    );

    // Memory model with an access log: {write, addr, data}.
    logic [63:0]  mem [logic [63:0]];
    logic [128:0] acc_log [64];
    int           n_acc = 0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                acc_log[n_acc[5:0]] <= {1'b1, mem_req_addr, mem_req_wdata};
            end else begin
                mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                mem_rsp_valid <= 1'b1;
                acc_log[n_acc[5:0]] <= {1'b0, mem_req_addr, 64'h0};
            end
            n_acc <= n_acc + 1;
        end
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-entry outcome, from R4/R5/R6.
    function automatic logic [1:0] lvl_verdict(input logic [63:0] e, input logic [2:0] a);
        if (e[2:0] == 3'b000) return 2'd1;
        if (e[7:3] != 5'b0 || e[51:PA_W] != '0) return 2'd3;
        if ((a & ~e[2:0]) != 3'b000) return 2'd2;
        return 2'd0;
    endfunction

    logic [63:0] ent [4];

    task automatic run_walk(input logic [47:0] gpa, input logic [2:0] acc, input logic ad,
                            input logic [1:0] exp_st, input string tag);
        logic [39:0]  base;
        logic [63:0]  eaddr [4];
        logic [128:0] exp_seq [8];
        int           n_exp;
        int           n0;
        int           cyc;
        logic [1:0]   got_st;
        logic [51:0]  got_hpa;
        logic [1:0]   v;
        bit           seq_ok;
        mem.delete();
        base = ROOT_BASE;
        for (int l = 0; l < 4; l++) begin
            eaddr[l] = {12'h0, base, gpa[47-9*l -: 9], 3'b000};
            mem[eaddr[l]] = ent[l];
            base = ent[l][51:12];
        end
        n_exp = 0;
        for (int l = 0; l < 4; l++) begin
            exp_seq[n_exp] = {1'b0, eaddr[l], 64'h0}; n_exp++;
            v = lvl_verdict(ent[l], acc);
            if (v != 2'd0) break;
            if (ad && !ent[l][8]) begin
                exp_seq[n_exp] = {1'b1, eaddr[l], ent[l] | 64'h100}; n_exp++;
            end
        end
        @(negedge clk);
        n0 = n_acc;
        req_gpa = gpa; req_acc = acc;
        req_root = {12'h0, ROOT_BASE, 5'b0, ad, 6'b0};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {"R1 busy ", tag}, 64'(req_ready), 64'h0);
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, {"R10 done seen ", tag}, 64'(done), 64'h1);
        got_st = status; got_hpa = hpa;
        check(got_st == exp_st, {"R4/R5/R6/R9 status ", tag}, 64'(got_st), 64'(exp_st));
        if (exp_st == 2'd0)
            check(got_hpa == {ent[3][51:12], gpa[11:0]}, {"R9 hpa ", tag}, 64'(got_hpa),
                  64'({ent[3][51:12], gpa[11:0]}));
        seq_ok = (n_acc - n0) == n_exp;
        for (int i = 0; i < n_exp && seq_ok; i++) begin
            if (acc_log[(n0 + i) % 64][128:64] != exp_seq[i][128:64]) seq_ok = 0;
            if (exp_seq[i][128] && acc_log[(n0 + i) % 64][63:0] != exp_seq[i][63:0]) seq_ok = 0;
        end
        check(seq_ok, {"R2/R3/R8 access sequence ", tag}, 64'(n_acc - n0), 64'(n_exp));
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, {"R10 pulse end ", tag},
              64'({done, req_ready}), 64'h1);
    endtask

    typedef struct packed {
        logic [47:0] gpa;
        logic [2:0]  acc;
        logic        ad;
        logic [11:0] f0, f1, f2, f3;
        logic [1:0]  st;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{48'h0000_0000_1abc, 3'b001, 1'b0, 12'h007, 12'h007, 12'h007, 12'h007, 2'd0},
        '{48'hABCD_EF12_3456, 3'b010, 1'b0, 12'h003, 12'h003, 12'h003, 12'h003, 2'd0},
        '{48'h1234_5678_9ABC, 3'b100, 1'b0, 12'h007, 12'h007, 12'h003, 12'h007, 2'd2},
        '{48'h0F0F_0F0F_0F0F, 3'b001, 1'b0, 12'h007, 12'h000, 12'h007, 12'h007, 2'd1},
        '{48'h7FFF_FFFF_F123, 3'b001, 1'b0, 12'h00F, 12'h007, 12'h007, 12'h007, 2'd3},
        '{48'h8000_4020_1FFF, 3'b011, 1'b1, 12'h007, 12'h007, 12'h007, 12'h007, 2'd0},
        '{48'h0001_0203_0405, 3'b001, 1'b1, 12'h107, 12'h007, 12'h107, 12'h007, 2'd0},
        '{48'h5555_AAAA_5555, 3'b111, 1'b0, 12'hE07, 12'hE07, 12'h007, 12'hF07, 2'd0},
        '{48'h3333_4444_5555, 3'b010, 1'b0, 12'h007, 12'h009, 12'h007, 12'h007, 2'd3},
        '{48'h0000_0000_0000, 3'b001, 1'b0, 12'h0F8, 12'h007, 12'h007, 12'h007, 2'd1},
        '{48'hFEDC_BA98_7654, 3'b010, 1'b1, 12'h007, 12'h007, 12'h001, 12'h007, 2'd2}
    };

    localparam logic [39:0] NEXT_BASE [4] = '{40'h20, 40'h30, 40'h40, 40'h123456};

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values
        check(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R12 reset outputs",
              64'({req_ready, done, mem_req_valid}), 64'h4);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            ent[0] = {12'h0, NEXT_BASE[0], VEC[i].f0};
            ent[1] = {12'h0, NEXT_BASE[1], VEC[i].f1};
            ent[2] = {12'h0, NEXT_BASE[2], VEC[i].f2};
            ent[3] = {12'h0, NEXT_BASE[3], VEC[i].f3};
            run_walk(VEC[i].gpa, VEC[i].acc, VEC[i].ad, VEC[i].st, $sformatf("vec%0d", i));
        end

        // R6: reserved bit at PA_W..51 (bit 50) in level 1 entry
        for (int l = 0; l < 4; l++) ent[l] = {12'h0, NEXT_BASE[l], 12'h007};
        ent[1][50] = 1'b1;
        run_walk(48'h2468_ACE0_1357, 3'b001, 1'b0, 2'd3, "r6_high_rsv");

        // R7: ignored high bits 63:52 and 11:9 set everywhere
        for (int l = 0; l < 4; l++) ent[l] = {12'hFFF, NEXT_BASE[l], 12'hE07};
        run_walk(48'h1111_2222_3333, 3'b111, 1'b0, 2'd0, "r7_ignored");

        // R11 with R8: memory stalls every other cycle, tracking on
        stall_mode = 1'b1;
        for (int l = 0; l < 4; l++) ent[l] = {12'h0, NEXT_BASE[l], 12'h007};
        run_walk(48'h9999_8888_7777, 3'b001, 1'b1, 2'd0, "r11_stall");
        stall_mode = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule